// File: doc/BRIEF.md
# Handshake Request Sequencer for a Byte-Wide Parallel Bus

This block is the request side of a byte-wide asynchronous parallel bus handshake. It pulls data words from a simple fetch interface and puts each word on the bus. It then signals each word to the far side with a request line that goes low and waits for the acknowledge line to answer. The acknowledge input is asynchronous, so it passes through a synchronizer before the sequencer reacts to its levels and changes.

The cycle runs as follows. Once a word is on the bus, a restart lowers the request line. When the acknowledge falls, the request goes high again and the next word is requested from the source in the same cycle. When the acknowledge rises, the request is lowered again, but only after the fetched word has reached the bus. A transfer count limits the number of request pulses. When the count runs out, a done pulse is raised and the block holds. Control logic can then add more count, which resumes the transfer, or stop it, which releases the bus. A watchdog ends the transfer with an error when the acknowledge stays still for too long.

Top module: `reqack_out_seq`

## Requirements
- R1: After reset, req_out is 1, and bus_oe, data_out, fetch_req, busy, done and err are all 0.
- R2: A start pulse holds req_out at 1, sets bus_oe and busy, and raises fetch_req for the first word. The fetched word is on data_out at least one cycle before req_out first falls.
- R3: The acknowledge is synchronized by two flops. When ack_in falls while req_out is 0, req_out rises after the third rising clock edge. When ack_in rises and the next word is ready, req_out falls after the third rising clock edge.
- R4: In the cycle where req_out rises because the acknowledge fell, fetch_req is 1 if more pulses remain.
- R5: A restart never happens while a fetch is outstanding. req_out stays 1 with the acknowledge high until fetch_valid delivers the word.
- R6: A start with count N (N > 0) gives exactly N falling edges on req_out. The words are shown in the order the source delivers them.
- R7: When the acknowledge rises after the last counted pulse, done pulses high for one cycle. After that, req_out stays 1 and busy stays 1 until more count is added or stop is pulsed.
- R8: An add_valid pulse with add_count K > 0 in the exhausted state fetches a new word and drives it on data_out before req_out falls. It then gives exactly K more pulses.
- R9: An add_valid pulse while pulses are still pending adds add_count to the remaining count.
- R10: A stop pulse in any busy state returns the block to idle in one cycle: req_out 1, bus_oe 0, data_out 0, fetch_req 0, busy 0.
- R11: While the block waits on the acknowledge, if the synchronized acknowledge does not change for tmo_limit consecutive cycles, the transfer aborts to idle and err is set. err is cleared by the next start. A tmo_limit of 0 disables the watchdog.
- R12: A start with count 0 gives no request pulse and no fetch. done pulses once and the block stays busy in the exhausted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (idle only) |
| start_count | input | CNT_W | Pulse count loaded on start |
| add_valid | input | 1 | Add count while busy |
| add_count | input | CNT_W | Pulses to add |
| stop | input | 1 | Abandon transfer and release bus |
| tmo_limit | input | TMO_W | Acknowledge timeout in cycles, 0 disables |
| ack_in | input | 1 | Asynchronous acknowledge from the bus |
| req_out | output | 1 | Request line level |
| bus_oe | output | 1 | Data and request drive enable |
| data_out | output | DATA_W | Data byte on the bus |
| fetch_req | output | 1 | Word wanted from the source |
| fetch_valid | input | 1 | Source delivers fetch_data this cycle |
| fetch_data | input | DATA_W | Word from the source |
| busy | output | 1 | Transfer active, including exhausted hold |
| done | output | 1 | One-cycle pulse when the count runs out |
| err | output | 1 | Watchdog abort flag |

## Verification
Assertions check several rules on every cycle:
- req_out only falls once the fetch has finished and, after a high phase, once the synchronized acknowledge is high.
- req_out only rises mid-transfer after the acknowledge falls.
- A start always begins with req_out high.
- done only appears with req_out high.
- The count never decrements from zero.
- An error always coincides with a released bus.

Other behaviours only the directed scenarios can show:
- the exact three-edge synchronizer latency;
- the number of pulses and the order of the words;
- resuming after exhaustion, with the data ahead of the request;
- extending the count mid-transfer;
- the watchdog being disabled by a zero limit.

// File: rtl/reqack_pkg.sv
package reqack_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_LOAD  = 3'd1,
    SQ_LOW   = 3'd2,
    SQ_HIGH  = 3'd3,
    SQ_EMPTY = 3'd4
  } seq_state_e;

endpackage

// File: rtl/reqack_rst_sync.sv
module reqack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] shf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= {shf_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = shf_q[STAGES-1];
endmodule

// File: rtl/reqack_ack_sync.sv
module reqack_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ack_in,
  output logic ack_s,
  output logic ack_edge
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], ack_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign ack_s    = chain_q[STAGES-1];
  assign ack_edge = ack_s ^ prev_q;
endmodule

// File: rtl/reqack_xfer_count.sv
module reqack_xfer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d, add_term, dec_term;
  logic             cnt_en;

  always_comb begin
    add_term = add_en ? add_val : '0;
    dec_term = {{(CNT_W-1){1'b0}}, dec};
    cnt_en   = load | add_en | dec;
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q + add_term - dec_term;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    dec |-> (cnt_q != '0 || add_en)); // R6
endmodule

// File: rtl/reqack_watchdog.sv
module reqack_watchdog #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             arm,
  input  logic             toggle,
  input  logic [TMO_W-1:0] limit,
  output logic             fire
);
  logic [TMO_W-1:0] wd_q, wd_d;
  logic             wd_en;

  always_comb begin
    wd_en = 1'b1;
    if (!arm || toggle)    wd_d = '0;
    else if (wd_q != '1)   wd_d = wd_q + 1'b1;
    else begin
      wd_d  = wd_q;
      wd_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    wd_q <= '0;
    else if (wd_en) wd_q <= wd_d;
  end

  assign fire = arm && !toggle && (limit != '0) && (wd_q >= limit);

  AST_WD_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !arm |=> (wd_q == '0)); // R11
endmodule

// File: rtl/reqack_out_seq.sv
module reqack_out_seq
  import reqack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int TMO_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              add_valid,
  input  logic [CNT_W-1:0]  add_count,
  input  logic              stop,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              ack_in,
  output logic              req_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              fetch_req,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int RST_STAGES = 2;

  logic rst_ni, ack_s, ack_edge, cnt_zero, wd_fire, wd_arm;
  logic cnt_load, add_en, dec, cnt_more, fetch_take, add_nz;

  seq_state_e        state_q, state_d;
  logic              pend_q, pend_d, have_q, have_d;
  logic              done_q, done_d, err_q, err_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  reqack_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  reqack_ack_sync #(.STAGES(SYNC_N)) u_ack (
    .clk(clk), .rst_ni(rst_ni), .ack_in(ack_in), .ack_s(ack_s), .ack_edge(ack_edge));

  reqack_xfer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .load(cnt_load), .load_val(start_count),
    .add_en(add_en), .add_val(add_count), .dec(dec), .zero(cnt_zero));

  assign wd_arm = (state_q == SQ_LOW) || (state_q == SQ_HIGH && !ack_s);

  reqack_watchdog #(.TMO_W(TMO_W)) u_wd (
    .clk(clk), .rst_ni(rst_ni), .arm(wd_arm), .toggle(ack_edge),
    .limit(tmo_limit), .fire(wd_fire));

  // Count extension is accepted in any busy state unless stop wins.
  assign add_en     = add_valid && (state_q != SQ_IDLE) && !stop;
  assign add_nz     = add_en && (add_count != '0);
  assign cnt_more   = !cnt_zero || add_nz;
  assign fetch_take = pend_q && fetch_valid;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    have_d   = have_q;
    data_d   = data_q;
    done_d   = 1'b0;
    err_d    = err_q;
    cnt_load = 1'b0;
    dec      = 1'b0;

    if (fetch_take) begin
      data_d = fetch_data;
      pend_d = 1'b0;
      have_d = 1'b1;
    end

    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          cnt_load = 1'b1;
          err_d    = 1'b0;
          have_d   = 1'b0;
          data_d   = '0;
          if (start_count != '0) begin
            state_d = SQ_LOAD;
            pend_d  = 1'b1;
          end else begin
            state_d = SQ_EMPTY;
            done_d  = 1'b1;
          end
        end
      end
      SQ_LOAD: begin
        // Word must already sit on the bus before the first restart.
        if (have_q && !pend_q) begin
          state_d = SQ_LOW;
          dec     = 1'b1;
          have_d  = 1'b0;
        end
      end
      SQ_LOW: begin
        if (!ack_s) begin
          state_d = SQ_HIGH;
          if (cnt_more) pend_d = 1'b1;
        end
      end
      SQ_HIGH: begin
        if (!have_q && !pend_q && cnt_more) begin
          pend_d = 1'b1;
        end else if (ack_s && have_q && !pend_q) begin
          state_d = SQ_LOW;
          dec     = 1'b1;
          have_d  = 1'b0;
        end else if (ack_s && !have_q && !pend_q) begin
          state_d = SQ_EMPTY;
          done_d  = 1'b1;
        end
      end
      SQ_EMPTY: begin
        if (add_nz) begin
          state_d = SQ_LOAD;
          pend_d  = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase

    if (wd_fire || (stop && state_q != SQ_IDLE)) begin
      state_d = SQ_IDLE;
      pend_d  = 1'b0;
      have_d  = 1'b0;
      data_d  = '0;
      dec     = 1'b0;
      done_d  = 1'b0;
      if (wd_fire) err_d = 1'b1;
    end
  end

  assign data_en = (data_d != data_q);

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      pend_q  <= 1'b0;
      have_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      have_q  <= have_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign req_out   = (state_q != SQ_LOW);
  assign bus_oe    = (state_q != SQ_IDLE);
  assign busy      = bus_oe;
  assign data_out  = data_q;
  assign fetch_req = pend_q;
  assign done      = done_q;
  assign err       = err_q;

  AST_START_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> req_out); // R2
  AST_RESTART_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(req_out) |-> $past(!fetch_req)); // R5
  AST_RESTART_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(req_out) && $past(state_q == SQ_HIGH)) |-> $past(ack_s)); // R3
  AST_RISE_ON_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(req_out) && busy) |-> !$past(ack_s)); // R4
  AST_DONE_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> (req_out && busy)); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_oe |-> (data_out == '0 && !fetch_req && req_out)); // R10
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(err) |-> !busy); // R11
endmodule

// File: tb/reqack_out_seq_bench.sv
module reqack_out_seq_bench;
  logic        clk, rst_n, start, add_valid, stop, ack_in, fetch_valid;
  logic [15:0] start_count, add_count, tmo_limit;
  logic [7:0]  fetch_data, data_out;
  logic        req_out, bus_oe, fetch_req, busy, done, err;

  int errors = 0, checks = 0, cyc = 0;
  int falls = 0, dones = 0;
  int word_ctr = 0, exp_ctr = 0, delay_cfg = 0, dly = 0;
  logic req_prev = 1'b1;

  reqack_out_seq u_reqack_out_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
    .add_valid(add_valid), .add_count(add_count), .stop(stop),
    .tmo_limit(tmo_limit), .ack_in(ack_in), .req_out(req_out),
    .bus_oe(bus_oe), .data_out(data_out), .fetch_req(fetch_req),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .busy(busy),
    .done(done), .err(err));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Word source: answers fetch_req after delay_cfg cycles
  always @(negedge clk) begin
    if (fetch_valid) begin
      fetch_valid <= 1'b0;
      word_ctr    <= word_ctr + 1;
    end else if (fetch_req) begin
      if (dly >= delay_cfg) begin
        fetch_valid <= 1'b1;
        fetch_data  <= 8'(word_ctr) ^ 8'h5A;
        dly         <= 0;
      end else dly <= dly + 1;
    end
  end

  always @(negedge clk) begin
    if (req_prev && !req_out) falls++;
    if (done) dones++;
    req_prev <= req_out;
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      report();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_req(logic v, string tag);
    for (int i = 0; i < 400; i++) begin
      if (req_out == v) return;
      @(negedge clk);
    end
    chk(tag, int'(req_out), int'(v));
  endtask

  task automatic skip(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start(int n);
    @(negedge clk);
    exp_ctr = word_ctr;
    start_count = 16'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_stop;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic do_add(int n);
    @(negedge clk); add_count = 16'(n); add_valid = 1'b1;
    @(negedge clk); add_valid = 1'b0;
  endtask

  task automatic handshake(string tag);
    wait_req(1'b0, tag);
    chk(tag, int'(data_out), int'(8'(exp_ctr) ^ 8'h5A));
    exp_ctr++;
    ack_in = 1'b0;
    wait_req(1'b1, tag);
    ack_in = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 req", int'(req_out), 1);
    chk("R1 oe/busy/fetch", int'({bus_oe, busy, fetch_req}), 0);
    chk("R1 data", int'(data_out), 0);
    chk("R1 done/err", int'({done, err}), 0);
  endtask

  task automatic t_basic;
    int f0, d0;
    logic [7:0] prev;
    delay_cfg = 0; f0 = falls; d0 = dones;
    do_start(4);
    chk("R2 req high after start", int'(req_out), 1);
    chk("R2 bus driven", int'({bus_oe, busy}), 3);
    chk("R2 fetch requested", int'(fetch_req), 1);
    prev = data_out;
    for (int i = 0; i < 50 && req_out; i++) begin prev = data_out; @(negedge clk); end
    chk("R2 word before req fall", int'(prev), int'(8'(exp_ctr) ^ 8'h5A));
    chk("R6 first word", int'(data_out), int'(8'(exp_ctr) ^ 8'h5A));
    exp_ctr++;
    ack_in = 1'b0;
    skip(2);
    chk("R3 req still low two edges after ack fall", int'(req_out), 0);
    skip(1);
    chk("R3 req high third edge after ack fall", int'(req_out), 1);
    chk("R4 fetch with req rise", int'(fetch_req), 1);
    ack_in = 1'b1;
    skip(2);
    chk("R3 req still high two edges after ack rise", int'(req_out), 1);
    skip(1);
    chk("R3 req low third edge after ack rise", int'(req_out), 0);
    handshake("R6 word 2");
    handshake("R6 word 3");
    handshake("R6 word 4");
    skip(12);
    chk("R6 pulse count", falls - f0, 4);
    chk("R7 one done pulse", dones - d0, 1);
    chk("R7 held busy with req high", int'({busy, req_out}), 3);
    do_stop();
  endtask

  task automatic t_slow_fetch;
    delay_cfg = 8;
    do_start(2);
    handshake("R5 word 1");
    skip(4);
    chk("R5 req held while fetch pending", int'({req_out, fetch_req}), 3);
    handshake("R5 word 2");
    skip(12);
    delay_cfg = 0;
    do_stop();
  endtask

  task automatic t_extend_after;
    int f0, d0;
    logic [7:0] prev;
    f0 = falls; d0 = dones;
    do_start(1);
    handshake("R8 pre word");
    skip(10);
    chk("R8 exhausted done", dones - d0, 1);
    do_add(3);
    prev = data_out;
    for (int i = 0; i < 50 && req_out; i++) begin prev = data_out; @(negedge clk); end
    chk("R8 new word before req fall", int'(prev), int'(8'(exp_ctr) ^ 8'h5A));
    handshake("R8 resumed 1");
    handshake("R8 resumed 2");
    handshake("R8 resumed 3");
    skip(12);
    chk("R8 total pulses", falls - f0, 4);
    chk("R8 second done", dones - d0, 2);
    do_stop();
  endtask

  task automatic t_extend_mid;
    int f0, d0;
    f0 = falls; d0 = dones;
    do_start(2);
    handshake("R9 word 1");
    do_add(2);
    handshake("R9 word 2");
    handshake("R9 word 3");
    handshake("R9 word 4");
    skip(12);
    chk("R9 extended pulses", falls - f0, 4);
    chk("R9 single done", dones - d0, 1);
    do_stop();
  endtask

  task automatic t_stop;
    do_start(5);
    handshake("R10 word 1");
    handshake("R10 word 2");
    wait_req(1'b0, "R10 third req");
    do_stop();
    chk("R10 req released", int'(req_out), 1);
    chk("R10 bus off", int'({bus_oe, busy, fetch_req}), 0);
    chk("R10 data cleared", int'(data_out), 0);
  endtask

  task automatic t_watchdog;
    tmo_limit = 16'd16;
    do_start(3);
    skip(60);
    chk("R11 aborted idle", int'(busy), 0);
    chk("R11 err set", int'(err), 1);
    chk("R11 req released", int'(req_out), 1);
    tmo_limit = 16'd0;
    do_start(1);
    chk("R11 err cleared by start", int'(err), 0);
    skip(100);
    chk("R11 zero limit disables", int'({busy, err}), 2);
    handshake("R11 late word");
    skip(10);
    tmo_limit = 16'd1000;
    do_stop();
  endtask

  task automatic t_zero;
    int f0, d0;
    f0 = falls; d0 = dones;
    do_start(0);
    skip(5);
    chk("R12 done without pulse", dones - d0, 1);
    chk("R12 no pulse", falls - f0, 0);
    chk("R12 busy no fetch", int'({busy, fetch_req}), 2);
    do_stop();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; add_valid = 1'b0;
    start_count = '0; add_count = '0; tmo_limit = 16'd1000;
    ack_in = 1'b1; fetch_valid = 1'b0; fetch_data = '0;
    skip(3);
    rst_n = 1'b1;
    skip(5);
    t_reset();
    t_basic();
    t_slow_fetch();
    t_extend_after();
    t_extend_mid();
    t_stop();
    t_watchdog();
    t_zero();
    skip(5);
    report();
  end
endmodule